// File: doc/BRIEF.md
# Register file with 16-bit pointer pairs

This block is the general-purpose register store of a small 8-bit processor core. It holds thirty-two byte-wide registers. Two read ports return register contents in the same cycle for the operand path, and one byte write port takes ALU results on the next rising clock.

The six highest registers double as three 16-bit address pointers, each made of a high byte and a low byte. A separate pointer port picks one pointer and one addressing mode, and returns an effective address in the same cycle. On the next rising edge it can write both bytes of that pointer back together. Post-increment uses the old value as the address and stores the value plus one. Pre-decrement stores the value minus one and uses it as the address. Displacement adds a small unsigned offset to form the address and leaves the pointer unchanged.

All ports are plain control and data pins. No part of this block streams data, so there is no valid/ready handshake and nothing is ever held back. Instruction decode, the ALU and the data memory sit outside the block.

Top module: `gpr_ptr_file`

## Requirements
- R1: After reset every one of the 32 registers reads as zero.
- R2: Each read port returns the current contents of the indexed register in the same cycle, with no clock delay.
- R3: A byte write with `wr_en` high stores `wr_data` into register `wr_idx` at the rising clock edge. It is visible on the read ports after that edge.
- R4: `ptr_sel` encodes 0 = pointer formed from registers 27 (high) and 26 (low), 1 = registers 29 (high) and 28 (low), 2 = registers 31 (high) and 30 (low).
- R5: `ptr_mode` 00 and 11 are displacement modes. `ptr_addr` is the pointer plus the zero-extended 6-bit `ptr_disp`, and the pointer is not modified.
- R6: `ptr_mode` 01 is post-increment. `ptr_addr` is the old pointer value, and with `ptr_en` high both bytes receive pointer+1 at the clock edge.
- R7: `ptr_mode` 10 is pre-decrement. `ptr_addr` is pointer-1, and with `ptr_en` high both bytes receive that same value at the clock edge.
- R8: Pointer arithmetic wraps modulo 65536. The carry or borrow runs from the low byte into the high byte.
- R9: When a byte write and a pointer write-back hit the same register in one cycle, the pointer value wins. A byte write to any other register in that cycle still lands.
- R10: With `ptr_en` low no pointer is modified. With `ptr_sel` = 3 no pointer is modified and `ptr_addr` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 5 | Register index for read port A |
| rd_a_data | output | 8 | Contents of register `rd_a_idx` |
| rd_b_idx | input | 5 | Register index for read port B |
| rd_b_data | output | 8 | Contents of register `rd_b_idx` |
| wr_en | input | 1 | Byte write enable |
| wr_idx | input | 5 | Byte write target register |
| wr_data | input | 8 | Byte write value |
| ptr_en | input | 1 | Allows the selected pointer to be written back |
| ptr_sel | input | 2 | Pointer select (0,1,2; 3 = none) |
| ptr_mode | input | 2 | 00/11 displacement, 01 post-increment, 10 pre-decrement |
| ptr_disp | input | 6 | Unsigned displacement for displacement modes |
| ptr_addr | output | 16 | Effective address, combinational |

## Verification
The bound assertions check four relations on every cycle: the address against the selected pointer in each mode, the written-back pointer against the previous address, the pointer left unchanged in displacement mode, and byte writes landing when no write-back claims the register. Other behaviours can only be shown by the bench's scenarios against its reference model. These are the all-zero reset state, the read-port contents, carry and borrow crossing the byte boundary at specific values, the outcome of a collision between a write-back and a byte write, and the absence of any update when `ptr_en` is low or the pointer select is 3.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    AM_DISP     = 2'b00,
    AM_POSTINC  = 2'b01,
    AM_PREDEC   = 2'b10,
    AM_DISP_ALT = 2'b11
  } addr_mode_t;
endpackage

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int ADDR_W  = 2 * DATA_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             wb_en,
  input  logic [IDX_W-1:0]                 wb_lo_idx,
  input  logic [IDX_W-1:0]                 wb_hi_idx,
  input  logic [ADDR_W-1:0]                wb_val,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
  // One flop row per register; pointer write-back outranks the byte port.
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit_lo, hit_hi, hit_wr;
    assign hit_lo = wb_en && (wb_lo_idx == IDX_W'(i));
    assign hit_hi = wb_en && (wb_hi_idx == IDX_W'(i));
    assign hit_wr = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)      regs_q[i] <= '0;
      else if (hit_lo) regs_q[i] <= wb_val[DATA_W-1:0];
      else if (hit_hi) regs_q[i] <= wb_val[ADDR_W-1:DATA_W];
      else if (hit_wr) regs_q[i] <= wr_data;
    end
  end
endmodule

// File: rtl/gpr_read_port.sv
module gpr_read_port #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  input  logic [IDX_W-1:0]                idx,
  output logic [DATA_W-1:0]               data
);
  assign data = regs[idx];
endmodule

// File: rtl/gpr_ptr_unit.sv
module gpr_ptr_unit
  import gpr_pkg::*;
#(
  parameter int NUM_REGS  = 32,
  parameter int DATA_W    = 8,
  parameter int DISP_W    = 6,
  parameter int NUM_PTRS  = 3,
  parameter int PTR_BASE  = 26,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int ADDR_W   = 2 * DATA_W,
  localparam int SEL_W    = $clog2(NUM_PTRS + 1),
  localparam int NUM_SLOT = 2 ** SEL_W
) (
  input  logic [2*NUM_PTRS-1:0][DATA_W-1:0] ptr_regs,
  input  logic                              ptr_en,
  input  logic [SEL_W-1:0]                  ptr_sel,
  input  logic [1:0]                        ptr_mode,
  input  logic [DISP_W-1:0]                 ptr_disp,
  output logic [ADDR_W-1:0]                 ptr_addr,
  output logic                              wb_en,
  output logic [IDX_W-1:0]                  wb_lo_idx,
  output logic [IDX_W-1:0]                  wb_hi_idx,
  output logic [ADDR_W-1:0]                 wb_val
);
  logic [NUM_SLOT-1:0][ADDR_W-1:0] ptr_vals;

  // Gather pairs; unused select slots read as zero.
  for (genvar p = 0; p < NUM_SLOT; p++) begin : g_pair
    if (p < NUM_PTRS) begin : g_real
      assign ptr_vals[p] = {ptr_regs[2*p+1], ptr_regs[2*p]};
    end else begin : g_none
      assign ptr_vals[p] = '0;
    end
  end

  addr_mode_t        mode;
  logic              sel_ok;
  logic              updates;
  logic [ADDR_W-1:0] cur;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] addr_raw;

  assign mode     = addr_mode_t'(ptr_mode);
  assign sel_ok   = int'(ptr_sel) < NUM_PTRS;
  assign cur      = ptr_vals[ptr_sel];
  assign disp_ext = {{(ADDR_W-DISP_W){1'b0}}, ptr_disp};

  always_comb begin
    unique case (mode)
      AM_POSTINC: begin
        addr_raw = cur;
        wb_val   = cur + ADDR_W'(1);
        updates  = 1'b1;
      end
      AM_PREDEC: begin
        wb_val   = cur - ADDR_W'(1);
        addr_raw = wb_val;
        updates  = 1'b1;
      end
      default: begin
        addr_raw = cur + disp_ext;
        wb_val   = cur;
        updates  = 1'b0;
      end
    endcase
  end

  assign ptr_addr  = sel_ok ? addr_raw : '0;
  assign wb_en     = ptr_en && sel_ok && updates;
  assign wb_lo_idx = IDX_W'(PTR_BASE + 2 * int'(ptr_sel));
  assign wb_hi_idx = IDX_W'(PTR_BASE + 2 * int'(ptr_sel) + 1);
endmodule

// File: rtl/gpr_ptr_file.sv
module gpr_ptr_file #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  parameter int DISP_W   = 6,
  parameter int NUM_PTRS = 3,
  parameter int PTR_BASE = 26,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int ADDR_W  = 2 * DATA_W,
  localparam int SEL_W   = $clog2(NUM_PTRS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ptr_en,
  input  logic [SEL_W-1:0]  ptr_sel,
  input  logic [1:0]        ptr_mode,
  input  logic [DISP_W-1:0] ptr_disp,
  output logic [ADDR_W-1:0] ptr_addr
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
  logic                            wb_en;
  logic [IDX_W-1:0]                wb_lo_idx;
  logic [IDX_W-1:0]                wb_hi_idx;
  logic [ADDR_W-1:0]               wb_val;

  gpr_storage #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wb_en(wb_en), .wb_lo_idx(wb_lo_idx), .wb_hi_idx(wb_hi_idx), .wb_val(wb_val),
    .regs_q(regs_q)
  );

  gpr_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_a (
    .regs(regs_q), .idx(rd_a_idx), .data(rd_a_data)
  );

  gpr_read_port #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rd_b (
    .regs(regs_q), .idx(rd_b_idx), .data(rd_b_data)
  );

  gpr_ptr_unit #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .DISP_W(DISP_W),
    .NUM_PTRS(NUM_PTRS), .PTR_BASE(PTR_BASE)
  ) u_ptr (
    .ptr_regs(regs_q[PTR_BASE +: 2*NUM_PTRS]),
    .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode), .ptr_disp(ptr_disp),
    .ptr_addr(ptr_addr),
    .wb_en(wb_en), .wb_lo_idx(wb_lo_idx), .wb_hi_idx(wb_hi_idx), .wb_val(wb_val)
  );
endmodule

// File: rtl/gpr_ptr_file_chk.sv
module gpr_ptr_file_chk #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 8,
  parameter int DISP_W   = 6,
  parameter int NUM_PTRS = 3,
  parameter int PTR_BASE = 26,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int ADDR_W  = 2 * DATA_W,
  localparam int SEL_W   = $clog2(NUM_PTRS + 1)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            wr_en,
  input logic [IDX_W-1:0]                wr_idx,
  input logic [DATA_W-1:0]               wr_data,
  input logic                            ptr_en,
  input logic [SEL_W-1:0]                ptr_sel,
  input logic [1:0]                      ptr_mode,
  input logic [DISP_W-1:0]               ptr_disp,
  input logic [ADDR_W-1:0]               ptr_addr,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q
);
  function automatic logic [ADDR_W-1:0] ptr_of(input logic [SEL_W-1:0] s);
    int lo;
    if (int'(s) >= NUM_PTRS) return '0;
    lo = PTR_BASE + 2 * int'(s);
    return {regs_q[IDX_W'(lo + 1)], regs_q[IDX_W'(lo)]};
  endfunction

  logic              sel_ok, is_inc, is_dec, is_disp, pair_hit, sel_d;
  logic [SEL_W-1:0]  sel_q;
  logic [ADDR_W-1:0] cur, after;

  assign sel_ok   = int'(ptr_sel) < NUM_PTRS;
  assign is_inc   = sel_ok && (ptr_mode == 2'b01);
  assign is_dec   = sel_ok && (ptr_mode == 2'b10);
  assign is_disp  = sel_ok && (ptr_mode[0] == ptr_mode[1]);
  assign cur      = ptr_of(ptr_sel);
  assign after    = ptr_of(sel_q);
  assign pair_hit = wr_en && ((wr_idx == IDX_W'(PTR_BASE + 2 * int'(ptr_sel))) ||
                              (wr_idx == IDX_W'(PTR_BASE + 2 * int'(ptr_sel) + 1)));
  assign sel_d    = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= ptr_sel;
  end

  // R6: post-increment addresses with the old value, stores value + 1
  a_r6_postinc_addr: assert property (@(posedge clk) disable iff (!rst_n)
    is_inc |-> ptr_addr == cur);
  a_r6_postinc_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && is_inc) |=> after == $past(ptr_addr) + ADDR_W'(1));

  // R7: pre-decrement stores the address it presents
  a_r7_predec_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_en && is_dec) |=> (after == $past(ptr_addr)) && (after == $past(cur) - ADDR_W'(1)));

  // R5: displacement address and pointer left alone
  a_r5_disp_addr: assert property (@(posedge clk) disable iff (!rst_n)
    is_disp |-> ptr_addr == cur + {{(ADDR_W-DISP_W){1'b0}}, ptr_disp});
  a_r5_disp_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (is_disp && !pair_hit) |=> after == $past(cur));

  // R3: byte write lands when no write-back claims the register
  a_r3_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(ptr_en && (is_inc || is_dec) && pair_hit)) |=>
      regs_q[$past(wr_idx)] == $past(wr_data));

  // R10: select 3 yields a zero address
  a_r10_no_sel_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_ok || sel_d) |-> ptr_addr == '0);
endmodule

bind gpr_ptr_file gpr_ptr_file_chk #(
  .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .DISP_W(DISP_W),
  .NUM_PTRS(NUM_PTRS), .PTR_BASE(PTR_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode), .ptr_disp(ptr_disp),
  .ptr_addr(ptr_addr), .regs_q(regs_q)
);

// File: tb/tb_gpr_ptr_file.sv
module tb_gpr_ptr_file;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [7:0]  rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, ptr_en = 1'b0;
  logic [1:0]  ptr_sel = '0, ptr_mode = '0;
  logic [5:0]  ptr_disp = '0;
  logic [15:0] ptr_addr;

  int model [32];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpr_ptr_file dut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_mode(ptr_mode), .ptr_disp(ptr_disp),
    .ptr_addr(ptr_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int ptr_val(input int s);
    return model[26 + 2*s + 1] * 256 + model[26 + 2*s];
  endfunction

  // Drive one cycle, check combinational outputs, then advance the model.
  task automatic step(input int we, input int widx, input int wdat, input int pe,
                      input int psel, input int pmode, input int pdisp,
                      input int ra, input int rb);
    int exp_addr, p, nv;
    string mtag;
    @(negedge clk);
    wr_en = 1'(we); wr_idx = 5'(widx); wr_data = 8'(wdat);
    ptr_en = 1'(pe); ptr_sel = 2'(psel); ptr_mode = 2'(pmode); ptr_disp = 6'(pdisp);
    rd_a_idx = 5'(ra); rd_b_idx = 5'(rb);
    #2;
    chk("R2 read port A", int'(rd_a_data), model[ra]);
    chk("R2 read port B", int'(rd_b_data), model[rb]);
    nv = -1;
    if (psel == 3) begin
      exp_addr = 0; mtag = "R10 no pointer";
    end else begin
      p = ptr_val(psel);
      if (pmode == 1) begin
        exp_addr = p; nv = (p + 1) & 16'hFFFF; mtag = "R6 R4 post-inc addr";
      end else if (pmode == 2) begin
        exp_addr = (p - 1) & 16'hFFFF; nv = exp_addr; mtag = "R7 R4 pre-dec addr";
      end else begin
        exp_addr = (p + pdisp) & 16'hFFFF; mtag = "R5 R4 displacement addr";
      end
    end
    chk(mtag, int'(ptr_addr), exp_addr);
    @(posedge clk);
    if (we != 0) model[widx] = wdat;
    if (pe != 0 && nv >= 0) begin
      model[26 + 2*psel]     = nv & 8'hFF;
      model[26 + 2*psel + 1] = (nv >> 8) & 8'hFF;
    end
  endtask

  task automatic peek(input int idx, input int exp, input string tag);
    @(negedge clk);
    wr_en = 1'b0; ptr_en = 1'b0; rd_a_idx = 5'(idx);
    #2;
    chk(tag, int'(rd_a_data), exp);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    foreach (model[i]) model[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < 32; i++) peek(i, 0, "R1 reset value");

    // R3 byte writes, then R6/R8 carry into the high byte
    step(1, 26, 'hFF, 0, 0, 0, 0, 0, 1);
    peek(26, 'hFF, "R3 byte write");
    step(1, 27, 'h12, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 1, 0, 1, 0, 26, 27);
    peek(26, 'h00, "R6 R8 post-inc low byte");
    peek(27, 'h13, "R6 R8 post-inc high byte");

    // R7/R8 pre-decrement from zero wraps
    step(0, 0, 0, 1, 1, 2, 0, 28, 29);
    peek(28, 'hFF, "R7 R8 pre-dec low byte");
    peek(29, 'hFF, "R7 R8 pre-dec high byte");

    // R8 borrow 0x0100 -> 0x00FF
    step(1, 26, 'h00, 0, 0, 0, 0, 0, 0);
    step(1, 27, 'h01, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 0, 2, 0, 0, 0);
    peek(26, 'hFF, "R8 borrow low byte");
    peek(27, 'h00, "R8 borrow high byte");

    // R5 displacement, both encodings, pointer unchanged
    step(1, 30, 'h34, 0, 0, 0, 0, 0, 0);
    step(1, 31, 'h12, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 1, 2, 0, 63, 30, 31);
    step(0, 0, 0, 1, 2, 3, 1, 30, 31);
    peek(30, 'h34, "R5 pointer low kept");
    peek(31, 'h12, "R5 pointer high kept");
    step(1, 30, 'hFE, 0, 0, 0, 0, 0, 0);
    step(1, 31, 'hFF, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    ptr_en = 1'b1; ptr_sel = 2'd2; ptr_mode = 2'b00; ptr_disp = 6'd5;
    #2 chk("R8 displacement wraps", int'(ptr_addr), 'h0003);

    // R9 collision: Y = FFFF post-inc while byte write hits its low register
    step(1, 28, 'hAA, 1, 1, 1, 0, 0, 0);
    peek(28, 'h00, "R9 write-back wins low");
    peek(29, 'h00, "R9 write-back wins high");
    step(1, 26, 'h55, 1, 1, 1, 0, 0, 0);
    peek(26, 'h55, "R9 other byte write lands");
    peek(28, 'h01, "R9 pointer still updated");

    // R10 disabled port and select 3
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    peek(26, 'h55, "R10 ptr_en low keeps low byte");
    peek(27, 'h00, "R10 ptr_en low keeps high byte");
    step(0, 0, 0, 1, 3, 2, 9, 0, 0);
    for (int i = 26; i < 32; i++) peek(i, model[i], "R10 select 3 no update");

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int ps;
      ps = ($urandom_range(0, 9) == 0) ? 3 : int'($urandom_range(0, 2));
      step(int'($urandom_range(0, 1)),
           ($urandom_range(0, 3) == 0) ? int'($urandom_range(26, 31)) : int'($urandom_range(0, 31)),
           int'($urandom_range(0, 255)), int'($urandom_range(0, 1)), ps,
           int'($urandom_range(0, 3)), int'($urandom_range(0, 63)),
           int'($urandom_range(0, 31)), int'($urandom_range(24, 31)));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule